// File: doc/BRIEF.md
# Linear Image Sensor Line-Scan Timing Generator

This block generates the line and pixel timing for the front end of a linear image sensor. It runs from one master clock. It works in one of two framing modes. In master framing the block drives a line-frame output: a run request starts a series of lines, and a fixed quiet gap separates one line from the next. In slave framing an external line-frame input does the framing. Its rising edge starts a line and its falling edge ends it.

Every line goes through the same phases in order:

1. A guarded charge-transfer pulse.
2. A run of pixels, split into dummy, optical-black and valid regions.

During the pixel run the block produces the following:

- Two complementary shift clocks, with a period of 12 master clocks in standard mode and 24 in even/odd mode.
- A reset pulse at the start of each shift period.
- A clamp window placed inside the black region.
- An end-of-conversion strobe that repeats every 4 master clocks.

Converted pixel data is captured on each end-of-conversion strobe. It can be read onto the output bus while the line frame is high.

The transfer width, the guardband, the region sizes and the clamp window are configuration inputs. These inputs are held steady while a line runs.

Top module: `ccd_line_timer`

## Requirements
- R1: In master framing (`modeSyncIn`=0), `runStop` high while idle makes `syncOut` high from the next clock. The line keeps `syncOut` high for exactly 2*`cfgGuard`+`cfgTrWidth`+N*P cycles, where N = `cfgDummy`+`cfgBlack`+`cfgValid` and P is the shift period.
- R2: Lowering `runStop` in the middle of a line does not shorten that line. No further line starts afterwards.
- R3: In slave framing (`modeSyncIn`=1), `runStop` is ignored and `syncOut` stays 0. A rising edge on `syncIn` starts a line, and `tr1` goes high `cfgGuard`+1 cycles after the edge.
- R4: In slave framing, a low `syncIn` ends the line. Pixel activity stops at the end of the current 4-cycle strobe group. The last `eoc` edge comes within 8 cycles of `syncIn` falling, after which `eoc`=1 and `phi2`=0.
- R5: `tr1` is high for exactly `cfgTrWidth` cycles. It is preceded and followed by `cfgGuard` cycles during which the shift clocks are parked (`phi1`=1, `phi2`=0) and `eoc`=1. The first low `eoc` comes 2*`cfgGuard`+`cfgTrWidth` cycles after the line starts.
- R6: The shift period P is 12 cycles when `cfgEvenOdd`=0 and 24 cycles when `cfgEvenOdd`=1. Within each period, `phi1` is high for the first P/2 cycles and `phi2` for the second P/2 cycles. `rs` is high for the first `RsWidth` (default 2) cycles of each period.
- R7: `eoc` is low for 2 cycles and then high for 2 cycles, repeating through the pixel run. This gives N*P/4 rising edges per line. After the last pixel the strobe stays high.
- R8: `clamp` is high for the whole period of each pixel whose index i (counted from 0 at the first dummy pixel) satisfies both of the following:
  - `cfgDummy`+`cfgClampStart` <= i < `cfgDummy`+`cfgClampEnd`
  - i < `cfgDummy`+`cfgBlack`
- R9: In master framing, `syncOut` stays low for exactly `GapCycles` (default 8) cycles between back-to-back lines. `eoc` stays high during that gap.
- R10: `pixData` is captured in the cycle where `eoc` rises. `dataOut` shows the captured word and `dataOe`=1 while the active frame level is high and `rdPixelN`=0. The active frame level is `syncOut` in master framing and `syncIn` in slave framing. While the frame level is low, `rdPixelN` is ignored: `dataOe`=0 and `dataOut`=0.
- R11: During and right after reset, the outputs take these values: `syncOut`=0, `tr1`=0, `phi1`=1, `phi2`=0, `rs`=0, `eoc`=1, `clamp`=0 and `dataOe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSyncIn | input | 1 | 0 = master framing, 1 = slave framing |
| runStop | input | 1 | Run request for master framing |
| syncIn | input | 1 | External line frame for slave framing |
| cfgEvenOdd | input | 1 | 0 = 12-cycle shift period, 1 = 24-cycle shift period |
| cfgGuard | input | CntW | Guard cycles on each side of the transfer pulse (>=1) |
| cfgTrWidth | input | CntW | Transfer pulse width in cycles (>=1) |
| cfgDummy | input | CntW | Dummy pixel count |
| cfgBlack | input | CntW | Optical-black pixel count |
| cfgValid | input | CntW | Valid pixel count (total pixel count must be >=1) |
| cfgClampStart | input | CntW | First clamped pixel, counted from the start of the black region |
| cfgClampEnd | input | CntW | End (exclusive) of the clamp window, counted from the start of the black region |
| pixData | input | DataW | Converted pixel word |
| rdPixelN | input | 1 | Active-low pixel read |
| syncOut | output | 1 | Driven line frame in master framing |
| tr1 | output | 1 | Charge transfer pulse |
| phi1 | output | 1 | Shift clock, first phase |
| phi2 | output | 1 | Shift clock, second phase |
| rs | output | 1 | Reset pulse |
| clamp | output | 1 | Black-level clamp window |
| eoc | output | 1 | End-of-conversion strobe |
| dataOut | output | DataW | Pixel output bus |
| dataOe | output | 1 | Pixel bus drive enable |

## Verification
Every output is a decode of registers that change at the clock edge where the stimulus is sampled, so each result is due a fixed number of cycles after its stimulus:

- `syncOut` rises one clock after `runStop` is seen.
- `tr1` rises `cfgGuard`+1 clocks after a `syncIn` edge.
- The first `eoc` fall comes 2*`cfgGuard`+`cfgTrWidth` clocks into the line.
- A captured word is on `dataOut` in the same cycle that `eoc` rises.

The bench drives its inputs and samples the outputs on falling clock edges. It counts cycles from the first sample that shows the line frame high, so every expected count is compared against the exact cycle offsets listed above. After a line is aborted, the bench watches a window of samples to bound where the last strobe edge falls.

// File: rtl/lsgen_pkg.sv
package lsgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_PIX,
    ST_HOLD,
    ST_GAP
  } lineState_e;

  // sequencer -> pixel path
  typedef struct packed {
    logic pixRun;     // pixel run phase active
    logic syncLevel;  // active line-frame level
  } lineStrobe_t;

  // pixel path -> sequencer
  typedef struct packed {
    logic groupEnd;   // last cycle of a 4-cycle strobe group
    logic pixDone;    // last cycle of the last pixel
  } pixStatus_t;

endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import lsgen_pkg::*;
#(
  parameter int CntW      = 8,
  parameter int GapCycles = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeSyncIn,
  input  logic            runStop,
  input  logic            syncIn,
  input  logic [CntW-1:0] cfgGuard,
  input  logic [CntW-1:0] cfgTrWidth,
  input  pixStatus_t      pixStat,
  output lineStrobe_t     strobe,
  output logic            syncOut,
  output logic            tr1
);

  localparam logic [CntW-1:0] CntOne  = CntW'(1);
  localparam logic [CntW-1:0] GapLast = CntW'(GapCycles - 1);
  localparam logic [CntW:0]   GapFull = (CntW+1)'(GapCycles);

  lineState_e      state, stateN;
  logic [CntW-1:0] cnt, cntN;
  logic            syncInQ;
  logic            startReq, syncDrop;
  logic [CntW-1:0] guardLast, trLast;

  assign guardLast = cfgGuard - CntOne;
  assign trLast    = cfgTrWidth - CntOne;
  assign startReq  = modeSyncIn ? (syncIn && !syncInQ) : runStop;
  assign syncDrop  = modeSyncIn && !syncIn;

  always_comb begin
    stateN = state;
    cntN   = cnt;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateN = ST_LEAD;
          cntN   = '0;
        end
      end
      ST_LEAD: begin
        if (syncDrop) stateN = ST_IDLE;
        else if (cnt == guardLast) begin
          stateN = ST_XFER;
          cntN   = '0;
        end else cntN = cnt + CntOne;
      end
      ST_XFER: begin
        if (syncDrop) stateN = ST_IDLE;
        else if (cnt == trLast) begin
          stateN = ST_TRAIL;
          cntN   = '0;
        end else cntN = cnt + CntOne;
      end
      ST_TRAIL: begin
        if (syncDrop) stateN = ST_IDLE;
        else if (cnt == guardLast) begin
          stateN = ST_PIX;
          cntN   = '0;
        end else cntN = cnt + CntOne;
      end
      ST_PIX: begin
        if (syncDrop && pixStat.groupEnd) stateN = ST_IDLE;
        else if (pixStat.pixDone) begin
          stateN = modeSyncIn ? ST_HOLD : ST_GAP;
          cntN   = '0;
        end
      end
      ST_HOLD: begin
        if (!syncIn) stateN = ST_IDLE;
      end
      ST_GAP: begin
        if (cnt == GapLast) begin
          cntN   = '0;
          stateN = (runStop && !modeSyncIn) ? ST_LEAD : ST_IDLE;
        end else cntN = cnt + CntOne;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      syncInQ <= 1'b0;
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      syncInQ <= syncIn;
    end
  end

  assign syncOut = !modeSyncIn &&
                   (state == ST_LEAD || state == ST_XFER ||
                    state == ST_TRAIL || state == ST_PIX);
  assign tr1     = (state == ST_XFER);

  assign strobe.pixRun    = (state == ST_PIX);
  assign strobe.syncLevel = modeSyncIn ? syncIn : syncOut;

  // checker: length of the current low run of syncOut, saturating
  logic [CntW:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= GapFull;
    else if (syncOut) lowRun <= '0;
    else if (lowRun < GapFull) lowRun <= lowRun + (CntW+1)'(1);
  end

  // R9
  sync_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> (lowRun >= GapFull));

  // R1
  run_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSyncIn && state == ST_IDLE && runStop) |=> syncOut);

  // R3
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeSyncIn |-> !syncOut);

endmodule

// File: rtl/ccd_pixel_path.sv
module ccd_pixel_path
  import lsgen_pkg::*;
#(
  parameter int CntW      = 8,
  parameter int DataW     = 10,
  parameter int StdPeriod = 12,
  parameter int EoPeriod  = 24,
  parameter int RsWidth   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineStrobe_t      strobe,
  output pixStatus_t       pixStat,
  input  logic             cfgEvenOdd,
  input  logic [CntW-1:0]  cfgDummy,
  input  logic [CntW-1:0]  cfgBlack,
  input  logic [CntW-1:0]  cfgValid,
  input  logic [CntW-1:0]  cfgClampStart,
  input  logic [CntW-1:0]  cfgClampEnd,
  input  logic [DataW-1:0] pixData,
  input  logic             rdPixelN,
  output logic             phi1,
  output logic             phi2,
  output logic             rs,
  output logic             eoc,
  output logic             clamp,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe
);

  localparam int PhW  = $clog2(EoPeriod);
  localparam int IdxW = CntW + 2;
  localparam logic [PhW-1:0]  PhOne  = PhW'(1);
  localparam logic [IdxW-1:0] IdxOne = IdxW'(1);

  logic [PhW-1:0]   phase, periodLast, halfPeriod;
  logic [IdxW-1:0]  pixIdx, pixTotal, clampLo, clampHiReq, blackEnd, clampHi;
  logic [DataW-1:0] pixLatch;
  logic             periodEnd;

  generate
    if (StdPeriod == EoPeriod) begin : g_fixedPeriod
      assign periodLast = PhW'(StdPeriod - 1);
      assign halfPeriod = PhW'(StdPeriod / 2);
    end else begin : g_selPeriod
      assign periodLast = cfgEvenOdd ? PhW'(EoPeriod - 1) : PhW'(StdPeriod - 1);
      assign halfPeriod = cfgEvenOdd ? PhW'(EoPeriod / 2) : PhW'(StdPeriod / 2);
    end
  endgenerate

  assign pixTotal   = IdxW'(cfgDummy) + IdxW'(cfgBlack) + IdxW'(cfgValid);
  assign clampLo    = IdxW'(cfgDummy) + IdxW'(cfgClampStart);
  assign clampHiReq = IdxW'(cfgDummy) + IdxW'(cfgClampEnd);
  assign blackEnd   = IdxW'(cfgDummy) + IdxW'(cfgBlack);
  assign clampHi    = (clampHiReq < blackEnd) ? clampHiReq : blackEnd;
  assign periodEnd  = (phase == periodLast);

  // phase and pixel index are held at zero outside the pixel run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      pixIdx <= '0;
    end else if (!strobe.pixRun) begin
      phase  <= '0;
      pixIdx <= '0;
    end else if (periodEnd) begin
      phase  <= '0;
      pixIdx <= pixIdx + IdxOne;
    end else begin
      phase  <= phase + PhOne;
    end
  end

  assign pixStat.groupEnd = strobe.pixRun && (phase[1:0] == 2'd3);
  assign pixStat.pixDone  = strobe.pixRun && periodEnd && (pixIdx == pixTotal - IdxOne);

  assign phi2  = strobe.pixRun && (phase >= halfPeriod);
  assign phi1  = !phi2;
  assign rs    = strobe.pixRun && (phase < PhW'(RsWidth));
  assign eoc   = !strobe.pixRun || phase[1];
  assign clamp = strobe.pixRun && (pixIdx >= clampLo) && (pixIdx < clampHi);

  // capture converted word in the cycle the strobe rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixLatch <= '0;
    else if (strobe.pixRun && phase[1:0] == 2'd1) pixLatch <= pixData;
  end

  assign dataOe  = strobe.syncLevel && !rdPixelN;
  assign dataOut = dataOe ? pixLatch : '0;

  // R7
  eoc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eoc) |=> !eoc);

  // R7
  eoc_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoc) |=> eoc);

  // R10
  latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eoc) |-> (pixLatch == $past(pixData)));

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import lsgen_pkg::*;
#(
  parameter int CntW      = 8,
  parameter int DataW     = 10,
  parameter int StdPeriod = 12,
  parameter int EoPeriod  = 24,
  parameter int RsWidth   = 2,
  parameter int GapCycles = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSyncIn,
  input  logic             runStop,
  input  logic             syncIn,
  input  logic             cfgEvenOdd,
  input  logic [CntW-1:0]  cfgGuard,
  input  logic [CntW-1:0]  cfgTrWidth,
  input  logic [CntW-1:0]  cfgDummy,
  input  logic [CntW-1:0]  cfgBlack,
  input  logic [CntW-1:0]  cfgValid,
  input  logic [CntW-1:0]  cfgClampStart,
  input  logic [CntW-1:0]  cfgClampEnd,
  input  logic [DataW-1:0] pixData,
  input  logic             rdPixelN,
  output logic             syncOut,
  output logic             tr1,
  output logic             phi1,
  output logic             phi2,
  output logic             rs,
  output logic             clamp,
  output logic             eoc,
  output logic [DataW-1:0] dataOut,
  output logic             dataOe
);

  lineStrobe_t strobe;
  pixStatus_t  pixStat;

  ccd_line_seq #(
    .CntW(CntW), .GapCycles(GapCycles)
  ) u_seq (
    .clk(clk), .rstN(rstN), .modeSyncIn(modeSyncIn), .runStop(runStop),
    .syncIn(syncIn), .cfgGuard(cfgGuard), .cfgTrWidth(cfgTrWidth),
    .pixStat(pixStat), .strobe(strobe), .syncOut(syncOut), .tr1(tr1)
  );

  ccd_pixel_path #(
    .CntW(CntW), .DataW(DataW), .StdPeriod(StdPeriod),
    .EoPeriod(EoPeriod), .RsWidth(RsWidth)
  ) u_pix (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixStat(pixStat),
    .cfgEvenOdd(cfgEvenOdd), .cfgDummy(cfgDummy), .cfgBlack(cfgBlack),
    .cfgValid(cfgValid), .cfgClampStart(cfgClampStart),
    .cfgClampEnd(cfgClampEnd), .pixData(pixData), .rdPixelN(rdPixelN),
    .phi1(phi1), .phi2(phi2), .rs(rs), .eoc(eoc), .clamp(clamp),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // R5
  tr_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    tr1 |-> (phi1 && !phi2 && eoc));

  // R9
  frame_low_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSyncIn && !syncOut) |-> (eoc && !phi2 && !tr1));

endmodule

// File: tb/ccd_line_timer_tb.sv
module ccd_line_timer_tb;

  localparam int CntW  = 8;
  localparam int DataW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSyncIn = 1'b0, runStop = 1'b0, syncIn = 1'b0, cfgEvenOdd = 1'b0;
  logic [CntW-1:0] cfgGuard = 8'd1, cfgTrWidth = 8'd1, cfgDummy = 8'd1,
                   cfgBlack = 8'd1, cfgValid = 8'd1, cfgClampStart = 8'd0,
                   cfgClampEnd = 8'd1;
  logic [DataW-1:0] pixData = '0;
  logic rdPixelN = 1'b1;
  logic syncOut, tr1, phi1, phi2, rs, clamp, eoc, dataOe;
  logic [DataW-1:0] dataOut;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  ccd_line_timer u_dut (
    .clk(clk), .rstN(rstN), .modeSyncIn(modeSyncIn), .runStop(runStop),
    .syncIn(syncIn), .cfgEvenOdd(cfgEvenOdd), .cfgGuard(cfgGuard),
    .cfgTrWidth(cfgTrWidth), .cfgDummy(cfgDummy), .cfgBlack(cfgBlack),
    .cfgValid(cfgValid), .cfgClampStart(cfgClampStart),
    .cfgClampEnd(cfgClampEnd), .pixData(pixData), .rdPixelN(rdPixelN),
    .syncOut(syncOut), .tr1(tr1), .phi1(phi1), .phi2(phi2), .rs(rs),
    .clamp(clamp), .eoc(eoc), .dataOut(dataOut), .dataOe(dataOe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // columns: evenOdd dummy black valid guard trW clampS clampE
  //          expHigh expTr expFirstLow expRises expClampCyc
  localparam int NV = 4;
  localparam int VEC [0:NV-1][0:12] = '{
    '{0, 2, 3, 4, 2, 3, 1, 3, 115, 3, 7, 27, 24},
    '{1, 1, 2, 2, 1, 4, 0, 5, 126, 4, 6, 30, 48},
    '{0, 0, 1, 1, 3, 1, 0, 1,  31, 1, 7,  6, 12},
    '{0, 3, 2, 1, 1, 1, 2, 4,  75, 1, 3, 18,  0}
  };

  task automatic setCfg(input int r);
    cfgEvenOdd    = VEC[r][0][0];
    cfgDummy      = 8'(VEC[r][1]);
    cfgBlack      = 8'(VEC[r][2]);
    cfgValid      = 8'(VEC[r][3]);
    cfgGuard      = 8'(VEC[r][4]);
    cfgTrWidth    = 8'(VEC[r][5]);
    cfgClampStart = 8'(VEC[r][6]);
    cfgClampEnd   = 8'(VEC[r][7]);
  endtask

  // one master-framing line, run request dropped right after it starts
  task automatic runOneLine(input int r);
    int hi = 0, trc = 0, first = -1, rises = 0, clc = 0, p2 = 0, rsc = 0, wt = 0;
    int n, per;
    logic prevEoc;
    n   = VEC[r][1] + VEC[r][2] + VEC[r][3];
    per = (VEC[r][0] != 0) ? 24 : 12;
    runStop = 1'b1;
    tick();
    while (!syncOut && wt < 50) begin tick(); wt++; end
    runStop = 1'b0;
    prevEoc = eoc;
    while (syncOut && hi < 5000) begin
      if (tr1) trc++;
      if (!eoc && first < 0) first = hi;
      if (eoc && !prevEoc) rises++;
      prevEoc = eoc;
      if (clamp) clc++;
      if (phi2) p2++;
      if (rs) rsc++;
      hi++;
      tick();
    end
    check($sformatf("R1 line %0d frame length", r), hi, VEC[r][8]);
    check($sformatf("R5 line %0d tr1 width", r), trc, VEC[r][9]);
    check($sformatf("R5 line %0d first eoc low", r), first, VEC[r][10]);
    check($sformatf("R7 line %0d eoc rises", r), rises, VEC[r][11]);
    check($sformatf("R8 line %0d clamp cycles", r), clc, VEC[r][12]);
    check($sformatf("R6 line %0d phi2 cycles", r), p2, n * per / 2);
    check($sformatf("R6 line %0d rs cycles", r), rsc, n * 2);
    repeat (12) tick();
  endtask

  initial begin
    // reset state, R11
    repeat (3) tick();
    check("R11 syncOut in reset", int'(syncOut), 0);
    check("R11 eoc in reset", int'(eoc), 1);
    rstN = 1'b1;
    tick();
    check("R11 syncOut", int'(syncOut), 0);
    check("R11 tr1", int'(tr1), 0);
    check("R11 phi1", int'(phi1), 1);
    check("R11 phi2", int'(phi2), 0);
    check("R11 rs", int'(rs), 0);
    check("R11 eoc", int'(eoc), 1);
    check("R11 clamp", int'(clamp), 0);
    check("R11 dataOe", int'(dataOe), 0);

    // vector table
    for (int r = 0; r < NV; r++) begin
      setCfg(r);
      tick();
      runOneLine(r);
    end

    // back-to-back lines, gap, stop at end of line (R1 R2 R9)
    begin
      int hi = 0, lo = 0, eocLow = 0, hi2 = 0, after = 0;
      setCfg(0);
      runStop = 1'b1;
      tick();
      while (!syncOut && lo < 50) begin tick(); lo++; end
      while (syncOut && hi < 5000) begin hi++; tick(); end
      check("R1 first of repeated lines", hi, 115);
      lo = 0;
      while (!syncOut && lo < 50) begin
        if (!eoc) eocLow++;
        lo++;
        tick();
      end
      check("R9 gap length", lo, 8);
      check("R9 eoc quiet in gap", eocLow, 0);
      while (syncOut && hi2 < 5000) begin
        if (hi2 == 20) runStop = 1'b0;
        hi2++;
        tick();
      end
      check("R2 line after mid-line stop", hi2, 115);
      for (int k = 0; k < 40; k++) begin
        if (syncOut) after++;
        tick();
      end
      check("R2 no line after stop", after, 0);
    end

    // slave framing: run request ignored (R3)
    begin
      int so = 0, el = 0, tc = 0;
      modeSyncIn = 1'b1;
      runStop = 1'b1;
      for (int k = 0; k < 40; k++) begin
        tick();
        if (syncOut) so++;
        if (!eoc) el++;
        if (tr1) tc++;
      end
      check("R3 syncOut stays low", so, 0);
      check("R3 no strobes from runStop", el, 0);
      check("R3 no transfer from runStop", tc, 0);
      runStop = 1'b0;
    end

    // slave line start, hold after pixels, read bus (R3 R7 R10)
    begin
      int idx = 0, trAt = -1, rises = 0;
      logic prevEoc;
      setCfg(2);
      pixData = 10'h2A5;
      rdPixelN = 1'b0;
      tick();
      check("R10 bus idle before frame", int'(dataOe), 0);
      syncIn = 1'b1;
      prevEoc = 1'b1;
      for (int k = 1; k <= 70; k++) begin
        tick();
        if (tr1 && trAt < 0) trAt = k;
        if (eoc && !prevEoc) rises++;
        prevEoc = eoc;
      end
      check("R3 tr1 delay after edge", trAt, 4);
      check("R7 slave line strobe count", rises, 6);
      check("R7 strobe parked after pixels", int'(eoc), 1);
      check("R10 dataOe while frame high", int'(dataOe), 1);
      check("R10 captured word", int'(dataOut), 'h2A5);
      syncIn = 1'b0;
      tick();
      check("R10 rdPixelN ignored, oe", int'(dataOe), 0);
      check("R10 rdPixelN ignored, data", int'(dataOut), 0);
      rdPixelN = 1'b1;
      idx = 0;
      repeat (4) tick();
    end

    // slave abort in mid pixel (R4)
    begin
      int lastEdge = 0, wt = 0;
      logic prevEoc;
      setCfg(1);
      tick();
      syncIn = 1'b1;
      tick();
      while (eoc && wt < 200) begin tick(); wt++; end
      repeat (10) tick();
      syncIn = 1'b0;
      prevEoc = eoc;
      for (int k = 1; k <= 20; k++) begin
        tick();
        if (eoc != prevEoc) lastEdge = k;
        prevEoc = eoc;
      end
      check("R4 last eoc edge within 8", int'(lastEdge <= 8), 1);
      check("R4 eoc parked after abort", int'(eoc), 1);
      check("R4 phi2 parked after abort", int'(phi2), 0);
      modeSyncIn = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule